// File: doc/BRIEF.md
# Sequential Binary-to-Decimal Seven-Segment Driver

This block takes a binary frequency value, rewrites it as decimal digits and produces one active-low seven-segment pattern per digit. It works one bit at a time. A start strobe captures the input word. After that, each pulse of a slow step enable performs one round of the double-dabble method: every decimal nibble of 5 or more first gets 3 added, and then the whole working register shifts left by one bit. The step enable is normally the reference clock divided by ten. With a 10-bit input the conversion needs ten steps, so it finishes well inside one second.

The digit and segment outputs keep showing the previous result until a new conversion completes. At that moment they all change together and `done` pulses high for one clock, so the display never flickers through intermediate values. A start strobe that arrives while a conversion is running is ignored. Reset clears the shown value to zero, ready for the next measurement.

Top module: `bcd_seg_driver`

## Requirements
- R1: While and after reset, `bcd_out` is all zero, every segment group shows the pattern for 0 (0000001), and `done` is 0. This holds even when reset arrives in the middle of a conversion.
- R2: After a conversion, `bcd_out` holds the decimal digits of the captured value. Units are in bits 3:0, tens in 7:4, hundreds in 11:8 and thousands in 15:12. Every nibble is 9 or less, and inputs from 0 to 1023 all convert correctly.
- R3: Exactly one shift step is taken on each clock where `step_en` is high during a conversion. Clocks without `step_en` do not advance the conversion. `done` goes high on the clock after the tenth step enable that follows the start.
- R4: `done` is a single-clock pulse. `bcd_out` and `seg_n` change only on the clock where `done` goes high, and they hold their value between conversions.
- R5: A `start` pulse during a conversion is ignored. Neither the result nor the completion timing of the running conversion changes.
- R6: `bin_in` is sampled only when an accepted `start` arrives. Changes to it afterwards have no effect on the result.
- R7: `seg_n` has 7 bits per digit, and digit d sits in bits 7d+6:7d. In each group, bit 6 is segment a and bit 0 is segment g, and 0 means lit. The codes are: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R8: Pulses on `step_en` while no conversion is running have no effect: `done` stays 0 and the outputs stay unchanged.
- R9: An input of 25 (0000011001) gives tens digit 2 and units digit 5. The tens segment group is then 0010010 and the units group is 0100100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| step_en | input | 1 | Conversion step enable (reference divided by ten) |
| start | input | 1 | Conversion start strobe |
| bin_in | input | VAL_W | Binary value to convert |
| bcd_out | output | 4*DIGITS | Decimal digits, units in the lowest nibble |
| seg_n | output | 7*DIGITS | Active-low segment patterns, a in the top bit of each group |
| done | output | 1 | One-clock pulse when a new result is shown |

## Verification
The bench builds the block with its default values, VAL_W = 10 and DIGITS = 4. This brings the full measurement range into reach: 0, 1023 and every value in between fit in four digits. The chosen values 25, 1023, 678 and 349 between them exercise every digit code 0 through 9. With ten steps per conversion, the bench can also place idle gaps, stray start pulses and input changes at known points inside a run and still predict the exact clock on which `done` appears.

// File: rtl/bcd_seg_driver.sv
module bcd_seg_driver #(
  parameter int VAL_W  = 10,
  parameter int DIGITS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  step_en,
  input  logic                  start,
  input  logic [VAL_W-1:0]      bin_in,
  output logic [4*DIGITS-1:0]   bcd_out,
  output logic [7*DIGITS-1:0]   seg_n,
  output logic                  done
);

  localparam int BCD_W = 4 * DIGITS;
  localparam int CNT_W = $clog2(VAL_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(VAL_W - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [VAL_W-1:0] bin_sr;
  logic [BCD_W-1:0] acc, acc_adj, acc_next;
  logic             ovf;
  logic             last_step;

  function automatic logic [6:0] seg_of(input logic [3:0] v);
    case (v)
      4'd0:    seg_of = 7'b0000001;
      4'd1:    seg_of = 7'b1001111;
      4'd2:    seg_of = 7'b0010010;
      4'd3:    seg_of = 7'b0000110;
      4'd4:    seg_of = 7'b1001100;
      4'd5:    seg_of = 7'b0100100;
      4'd6:    seg_of = 7'b0100000;
      4'd7:    seg_of = 7'b0001111;
      4'd8:    seg_of = 7'b0000000;
      4'd9:    seg_of = 7'b0000100;
      default: seg_of = 7'b1111111;
    endcase
  endfunction

  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign acc_adj[4*d +: 4] = (acc[4*d +: 4] >= 4'd5) ? acc[4*d +: 4] + 4'd3 : acc[4*d +: 4];
    assign seg_n[7*d +: 7]   = seg_of(bcd_out[4*d +: 4]);

    p_digit_range_r2: assert property (@(posedge clk) disable iff (rst)
      bcd_out[4*d +: 4] <= 4'd9);
  end

  assign {ovf, acc_next} = {acc_adj, bin_sr[VAL_W-1]};
  assign last_step       = busy && step_en && (cnt == LAST);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      bin_sr  <= '0;
      acc     <= '0;
      bcd_out <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy   <= 1'b1;
          cnt    <= '0;
          bin_sr <= bin_in;
          acc    <= '0;
        end
      end else if (step_en) begin
        acc    <= acc_next;
        bin_sr <= bin_sr << 1;
        cnt    <= cnt + CNT_W'(1);
        if (last_step) begin
          busy    <= 1'b0;
          bcd_out <= acc_next;
          done    <= 1'b1;
        end
      end
    end
  end

  logic chk_live;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) chk_live <= 1'b0;
    else     chk_live <= 1'b1;
  end

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    busy && step_en |-> !ovf);

  p_step_hold_r3: assert property (@(posedge clk) disable iff (rst)
    busy && !step_en |=> busy && $stable(cnt));

  p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
    chk_live && !done |-> $stable(bcd_out));

  p_done_needs_run_r8: assert property (@(posedge clk) disable iff (rst)
    chk_live && done |-> $past(busy));

endmodule

// File: tb/test_bcd_seg_driver.sv
module test_bcd_seg_driver;
  localparam int CLK_PERIOD = 10;
  localparam int VAL_W  = 10;
  localparam int DIGITS = 4;

  logic clk = 0;
  logic rst = 1;
  logic step_en = 0;
  logic start = 0;
  logic [VAL_W-1:0] bin_in = '0;
  logic [4*DIGITS-1:0] bcd_out;
  logic [7*DIGITS-1:0] seg_n;
  logic done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  bcd_seg_driver #(.VAL_W(VAL_W), .DIGITS(DIGITS)) i_bcd_seg_driver (
    .clk(clk), .rst(rst), .step_en(step_en), .start(start),
    .bin_in(bin_in), .bcd_out(bcd_out), .seg_n(seg_n), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] exp_bcd(input int v);
    exp_bcd = {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
  endfunction

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] t [10] = '{7'b0000001, 7'b1001111, 7'b0010010, 7'b0000110, 7'b1001100,
                           7'b0100100, 7'b0100000, 7'b0001111, 7'b0000000, 7'b0000100};
    exp_seg = (v < 10) ? t[v] : 7'b1111111;
  endfunction

  function automatic logic [27:0] exp_segs(input logic [15:0] b);
    exp_segs = {exp_seg(b[15:12]), exp_seg(b[11:8]), exp_seg(b[7:4]), exp_seg(b[3:0])};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input int v);
    @(negedge clk); bin_in = VAL_W'(v); start = 1;
    @(negedge clk); start = 0;
  endtask

  // steps n enables with gap idle clocks after each; returns clocks with done seen before the last
  task automatic run_steps(input int n, input int gap, output int early_done);
    early_done = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); step_en = 1;
      @(negedge clk); step_en = 0;
      if (i != n - 1 && done) early_done++;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (i != n - 1 && done) early_done++;
      end
    end
  endtask

  task automatic convert_and_check(input int v, input string req);
    int early;
    logic [15:0] eb;
    eb = exp_bcd(v);
    pulse_start(v);
    run_steps(VAL_W, 0, early);
    check(early == 0, req, "no early done", early, 0);
    check(done == 1'b1, req, "done after last step", done, 1);
    check(bcd_out == eb, req, "digits", bcd_out, eb);
    check(seg_n == exp_segs(eb), "R7", "segments", seg_n, exp_segs(eb));
    @(negedge clk);
    check(done == 1'b0, "R4", "done single pulse", done, 0);
  endtask

  task automatic t_reset();
    check(bcd_out == '0, "R1", "reset digits", bcd_out, 0);
    check(seg_n == {4{7'b0000001}}, "R1", "reset segments", seg_n, {4{7'b0000001}});
    check(done == 1'b0, "R1", "reset done", done, 0);
  endtask

  task automatic t_twenty_five();
    convert_and_check(25, "R9");
    check(seg_n[13:7] == 7'b0010010, "R9", "tens segments", seg_n[13:7], 7'b0010010);
    check(seg_n[6:0] == 7'b0100100, "R9", "units segments", seg_n[6:0], 7'b0100100);
  endtask

  task automatic t_values();
    convert_and_check(0, "R2");
    convert_and_check(1023, "R2");
    convert_and_check(678, "R2");
    convert_and_check(349, "R2");
    convert_and_check(999, "R2");
    convert_and_check(1000, "R2");
  endtask

  task automatic t_pacing();
    int early;
    logic [15:0] held;
    held = bcd_out;
    pulse_start(512);
    run_steps(VAL_W - 1, 2, early);
    check(early == 0 && done == 0, "R3", "no done before tenth step", early + done, 0);
    repeat (5) @(negedge clk);
    check(done == 0, "R3", "idle clocks do not advance", done, 0);
    check(bcd_out == held, "R4", "held during run", bcd_out, held);
    run_steps(1, 0, early);
    check(done == 1, "R3", "done after tenth step", done, 1);
    check(bcd_out == exp_bcd(512), "R3", "paced result", bcd_out, exp_bcd(512));
    @(negedge clk);
    check(done == 0 && bcd_out == exp_bcd(512), "R4", "result holds after pulse",
          bcd_out, exp_bcd(512));
  endtask

  task automatic t_busy_start();
    int early;
    pulse_start(123);
    run_steps(3, 0, early);
    pulse_start(900);
    check(done == 0, "R5", "no done from stray start", done, 0);
    run_steps(VAL_W - 3, 0, early);
    check(early == 0 && done == 1, "R5", "timing unchanged", done, 1);
    check(bcd_out == exp_bcd(123), "R5", "first value kept", bcd_out, exp_bcd(123));
  endtask

  task automatic t_input_change();
    int early;
    pulse_start(407);
    bin_in = VAL_W'(58);
    run_steps(VAL_W, 0, early);
    check(bcd_out == exp_bcd(407), "R6", "input sampled at start", bcd_out, exp_bcd(407));
  endtask

  task automatic t_idle_steps();
    logic [15:0] held;
    int seen;
    held = bcd_out;
    seen = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2 * VAL_W; i++) begin
      @(negedge clk); step_en = 1;
      @(negedge clk); step_en = 0;
      if (done) seen++;
    end
    check(seen == 0, "R8", "no done while idle", seen, 0);
    check(bcd_out == held, "R8", "digits unchanged while idle", bcd_out, held);
  endtask

  task automatic t_mid_reset();
    int early;
    pulse_start(777);
    run_steps(4, 0, early);
    @(negedge clk); rst = 1;
    @(negedge clk);
    check(bcd_out == '0 && done == 0, "R1", "mid-run reset clears", bcd_out, 0);
    rst = 0;
    run_steps(VAL_W, 0, early);
    check(early == 0 && done == 0 && bcd_out == '0, "R1", "aborted run gives no result",
          bcd_out, 0);
    check(seg_n == {4{7'b0000001}}, "R1", "segments show zero", seg_n, {4{7'b0000001}});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_twenty_five();
    t_values();
    t_pacing();
    t_busy_start();
    t_input_change();
    t_idle_steps();
    t_mid_reset();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule